// File: doc/BRIEF.md
# Host Configuration Load Port

This block is a register-mapped slave that a host processor uses to push a configuration bitstream into a programmable device. The host talks to it over a small bus with a select, read and write strobes, a 2-bit word address and a 32-bit data bus. Four registers sit behind that bus: a control register, a status register, a write-acknowledge register and a data port.

Before any data is accepted, the host has to arm the port by writing the program bit low and then high. Each accepted data write is split into bytes and sent out one byte per cycle, low byte first, over a valid/ready byte stream. While a word is still being sent, the port is busy, and the write-acknowledge flag tells the host when the next item may be written.

Misuse and a bad preamble are recorded as a 2-bit error code. One level interrupt output carries two causes, each with its own enable. When daisy-chain mode is on, every byte after a programmed number of local bytes goes to a separate downstream stream instead of the local one.

Top module: `cfg_host_port`

## Requirements
- R1: After reset, the control register reads 0x00000001 (program bit = 1, everything else 0). The status register reads 0, the write-acknowledge register reads 0, `irq` is low, and neither byte stream is valid.
- R2: The port becomes armed only when a control write sets bit 0 to 1 while the stored bit 0 is 0. Writing 1 when it is already 1 does not arm the port. A data write (address 3) while the port is not armed is dropped and sets error code 01.
- R3: Register read data shows on `rdata` in the cycle after the read strobe. The write-acknowledge register (address 2) bit 0 reads 1 exactly when the port is armed and no word is in flight.
- R4: Control bits [5:4] set how many bytes each data write carries: 00 gives 1 byte, 01 gives 2 bytes, 10 or 11 gives 4 bytes. The bytes leave low byte first, one per cycle while the receiving ready is high.
- R5: After arming, the low byte of the first accepted data write must be 0xA5. If it is not, the write is dropped, error code 11 is set, and the port keeps waiting for 0xA5.
- R6: A data write that arrives while a word is still in flight is ignored and sets error code 10. The word in flight is unaffected.
- R7: When control bit 1 (daisy) is set, the first N bytes after arming go to `cfg_byte`, where N is control bits [31:16]. All later bytes go to `chain_byte`. When bit 1 is clear, every byte goes to `cfg_byte`.
- R8: When control bit 2 is set, a recorded error raises `irq`. The interrupt stays high until the status register is read or the port is re-armed.
- R9: When control bit 3 is set, completing the last byte of a word raises `irq`. The interrupt stays high until the status register is read or the port is re-armed.
- R10: The status register (address 1) reads error code in bits [1:0], the accept-ready flag in bit 2 and the armed flag in bit 3. Re-arming clears the error code to 00.
- R11: While the selected byte stream is valid but not ready, its byte value and valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Bus select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 write-ack, 3 data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |
| cfg_byte | output | 8 | Local configuration byte |
| cfg_valid | output | 1 | Local byte valid |
| cfg_ready | input | 1 | Local receiver ready |
| chain_byte | output | 8 | Downstream chain byte |
| chain_valid | output | 1 | Downstream byte valid |
| chain_ready | input | 1 | Downstream receiver ready |

## Verification
Each result has a fixed latency, and the bench samples at that point:
- Read data is registered, so it is due one edge after the strobe. The bench reads it at the falling edge that follows.
- Error codes and interrupt flags are captured at the edge that takes the write, so they are checked right after the write task returns.
- The first byte of an accepted word is valid after that same edge. The following bytes come out one per edge while ready is high.
- The bench counts bytes only on valid-and-ready edges. It waits on the write-acknowledge flag before each word, so the byte order it expects does not depend on how long a word stays in flight.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_WACK = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_UNARMED = 2'b01,
    ERR_BUSY    = 2'b10,
    ERR_SYNC    = 2'b11
  } err_e;

  // bytes carried by one data write for a width code
  function automatic int width_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [3:0] pack_status(input err_e err, input logic rdy,
                                             input logic armed);
    return {armed, rdy, err};
  endfunction
endpackage

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs #(
  parameter int WORD_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               prog_in,
  input  logic               daisy_in,
  input  logic               ie_err_in,
  input  logic               ie_rdy_in,
  input  logic [1:0]         width_in,
  input  logic [LIMIT_W-1:0] limit_in,
  output logic               daisy_en,
  output logic               ie_err,
  output logic               ie_rdy,
  output logic [1:0]         width,
  output logic [LIMIT_W-1:0] limit,
  output logic               arm_pulse,
  output logic               disarm_pulse,
  output logic [WORD_W-1:0]  ctrl_rd
);
  logic prog_q;

  // arming needs the stored program bit low and the new value high
  assign arm_pulse    = ctl_wr & ~prog_q & prog_in;
  assign disarm_pulse = ctl_wr & prog_q & ~prog_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q   <= 1'b1;
      daisy_en <= 1'b0;
      ie_err   <= 1'b0;
      ie_rdy   <= 1'b0;
      width    <= 2'b00;
      limit    <= '0;
    end else if (ctl_wr) begin
      prog_q   <= prog_in;
      daisy_en <= daisy_in;
      ie_err   <= ie_err_in;
      ie_rdy   <= ie_rdy_in;
      width    <= width_in;
      limit    <= limit_in;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[0]   = prog_q;
    ctrl_rd[1]   = daisy_en;
    ctrl_rd[2]   = ie_err;
    ctrl_rd[3]   = ie_rdy;
    ctrl_rd[5:4] = width;
    ctrl_rd[16 +: LIMIT_W] = limit;
  end
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int WORD_W  = 32,
  parameter int LIMIT_W = 16,
  parameter int LEN_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  load_data,
  input  logic [LEN_W-1:0]   load_len,
  input  logic               abort,
  input  logic               clear_cnt,
  input  logic               daisy_en,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               cfg_ready,
  input  logic               chain_ready,
  output logic               busy,
  output logic [7:0]         out_byte,
  output logic               cfg_valid,
  output logic               chain_valid,
  output logic               word_done
);
  logic [WORD_W-1:0]  sh_data;
  logic [LEN_W-1:0]   sh_left;
  logic [LIMIT_W-1:0] lcl_cnt;
  logic               to_chain;
  logic               take;

  assign busy        = (sh_left != '0);
  assign to_chain    = daisy_en && (lcl_cnt >= limit);
  assign out_byte    = sh_data[7:0];
  assign cfg_valid   = busy & ~to_chain;
  assign chain_valid = busy & to_chain;
  assign take        = to_chain ? (chain_valid & chain_ready) : (cfg_valid & cfg_ready);
  assign word_done   = take && (sh_left == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_data <= '0;
      sh_left <= '0;
    end else if (abort) begin
      sh_left <= '0;
    end else if (load) begin
      sh_data <= load_data;
      sh_left <= load_len;
    end else if (take) begin
      sh_data <= sh_data >> 8;
      sh_left <= sh_left - LEN_W'(1);
    end
  end

  // saturating count of bytes delivered to the local stream since arming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  lcl_cnt <= '0;
    else if (clear_cnt)                          lcl_cnt <= '0;
    else if (take && !to_chain && (lcl_cnt != '1)) lcl_cnt <= lcl_cnt + 1'b1;
  end
endmodule

// File: rtl/cfg_irq.sv
module cfg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic done_evt,
  input  logic clear,
  input  logic ie_err,
  input  logic ie_rdy,
  output logic irq
);
  logic err_pend, rdy_pend;

  // a new event in the clearing cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pend <= 1'b0;
      rdy_pend <= 1'b0;
    end else begin
      err_pend <= err_evt  | (err_pend & ~clear);
      rdy_pend <= done_evt | (rdy_pend & ~clear);
    end
  end

  assign irq = (ie_err & err_pend) | (ie_rdy & rdy_pend);
endmodule

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_port_pkg::*;
#(
  parameter int         WORD_W    = 32,
  parameter int         LIMIT_W   = 16,
  parameter logic [7:0] SYNC_BYTE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq,
  output logic [7:0]        cfg_byte,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [7:0]        chain_byte,
  output logic              chain_valid,
  input  logic              chain_ready
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LEN_W      = $clog2(WORD_BYTES + 1);

  // named events for the checker
  logic ctl_wr, dat_wr, sts_rd;
  logic bad_unarmed, bad_busy, bad_sync, dwr_accept, err_evt, word_done;
  logic arm_pulse, disarm_pulse, busy, ready_flag;
  logic armed_q, expect_sync_q;
  err_e err_q, err_new;

  logic               daisy_en, ie_err, ie_rdy;
  logic [1:0]         width;
  logic [LIMIT_W-1:0] limit;
  logic [WORD_W-1:0]  ctrl_rd;
  logic [7:0]         out_byte;
  logic               unused_wbits;

  assign unused_wbits = &{1'b0, wdata[15:6]};

  assign ctl_wr = sel & wr & (addr == A_CTRL);
  assign dat_wr = sel & wr & (addr == A_DATA);
  assign sts_rd = sel & rd & (addr == A_STAT);

  cfg_ctrl_regs #(.WORD_W(WORD_W), .LIMIT_W(LIMIT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .prog_in(wdata[0]), .daisy_in(wdata[1]), .ie_err_in(wdata[2]),
    .ie_rdy_in(wdata[3]), .width_in(wdata[5:4]), .limit_in(wdata[16 +: LIMIT_W]),
    .daisy_en(daisy_en), .ie_err(ie_err), .ie_rdy(ie_rdy), .width(width),
    .limit(limit), .arm_pulse(arm_pulse), .disarm_pulse(disarm_pulse),
    .ctrl_rd(ctrl_rd)
  );

  assign bad_unarmed = dat_wr & ~armed_q;
  assign bad_busy    = dat_wr & armed_q & busy;
  assign bad_sync    = dat_wr & armed_q & ~busy & expect_sync_q & (wdata[7:0] != SYNC_BYTE);
  assign dwr_accept  = dat_wr & armed_q & ~busy & ~bad_sync;
  assign err_evt     = bad_unarmed | bad_busy | bad_sync;
  assign ready_flag  = armed_q & ~busy;

  always_comb begin
    err_new = ERR_NONE;
    if (bad_unarmed)   err_new = ERR_UNARMED;
    else if (bad_busy) err_new = ERR_BUSY;
    else if (bad_sync) err_new = ERR_SYNC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q       <= 1'b0;
      expect_sync_q <= 1'b0;
      err_q         <= ERR_NONE;
    end else begin
      if (arm_pulse) begin
        armed_q       <= 1'b1;
        expect_sync_q <= 1'b1;
        err_q         <= ERR_NONE;
      end else begin
        if (disarm_pulse) armed_q <= 1'b0;
        if (dwr_accept)   expect_sync_q <= 1'b0;
        if (err_evt)      err_q <= err_new;
      end
    end
  end

  cfg_serializer #(.WORD_W(WORD_W), .LIMIT_W(LIMIT_W), .LEN_W(LEN_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(dwr_accept), .load_data(wdata),
    .load_len(LEN_W'(width_bytes(width))), .abort(arm_pulse | disarm_pulse),
    .clear_cnt(arm_pulse), .daisy_en(daisy_en), .limit(limit),
    .cfg_ready(cfg_ready), .chain_ready(chain_ready), .busy(busy),
    .out_byte(out_byte), .cfg_valid(cfg_valid), .chain_valid(chain_valid),
    .word_done(word_done)
  );

  assign cfg_byte   = out_byte;
  assign chain_byte = out_byte;

  cfg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .done_evt(word_done),
    .clear(sts_rd | arm_pulse), .ie_err(ie_err), .ie_rdy(ie_rdy), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (sel && rd) begin
      case (addr)
        A_CTRL:  rdata <= ctrl_rd;
        A_STAT:  rdata <= WORD_W'(pack_status(err_q, ready_flag, armed_q));
        A_WACK:  rdata <= WORD_W'(ready_flag);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_host_port_chk.sv
module cfg_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_valid,
  input logic       chain_valid,
  input logic       cfg_ready,
  input logic [7:0] cfg_byte,
  input logic       armed,
  input logic       daisy_en,
  input logic       busy,
  input logic       dwr_accept,
  input logic       bad_busy,
  input logic       bad_unarmed,
  input logic       err_evt,
  input logic       ie_err,
  input logic       irq,
  input logic [1:0] err_code
);
  // R7
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_valid, chain_valid}));

  // R7
  chain_needs_daisy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_valid |-> daisy_en);

  // R2
  flow_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid | chain_valid) |-> armed);

  // R4
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_accept |=> busy);

  // R6
  busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_busy |=> (err_code == 2'b10));

  // R2
  unarmed_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_unarmed |=> (err_code == 2'b01));

  // R8
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && ie_err) |=> irq);

  // R11
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> $stable(cfg_byte));
endmodule

bind cfg_host_port cfg_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .chain_valid(chain_valid),
  .cfg_ready(cfg_ready), .cfg_byte(cfg_byte), .armed(armed_q),
  .daisy_en(daisy_en), .busy(busy), .dwr_accept(dwr_accept),
  .bad_busy(bad_busy), .bad_unarmed(bad_unarmed), .err_evt(err_evt),
  .ie_err(ie_err), .irq(irq), .err_code(err_q)
);

// File: tb/cfg_host_port_tb.sv
module cfg_host_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 0, rd = 0, wr = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  cfg_byte, chain_byte;
  logic        cfg_valid, chain_valid;
  logic        cfg_ready = 1'b1, chain_ready = 1'b1;

  int total = 0, bad = 0;
  logic [7:0] loc_b [0:255];
  logic [7:0] chn_b [0:255];
  int loc_n = 0, chn_n = 0;

  always #4 clk = ~clk;

  cfg_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .cfg_byte(cfg_byte),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .chain_byte(chain_byte),
    .chain_valid(chain_valid), .chain_ready(chain_ready)
  );

  always @(posedge clk) begin
    if (cfg_valid && cfg_ready && loc_n < 256) begin loc_b[loc_n] = cfg_byte; loc_n++; end
    if (chain_valid && chain_ready && chn_n < 256) begin chn_b[chn_n] = chain_byte; chn_n++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    @(negedge clk); sel = 0; rd = 0; d = rdata;
  endtask

  function automatic logic [31:0] ctl(input logic prog, input logic daisy,
      input logic ie_e, input logic ie_r, input logic [1:0] w, input logic [15:0] lim);
    return {lim, 10'd0, w, ie_r, ie_e, daisy, prog};
  endfunction

  task automatic arm(input logic daisy, input logic ie_e, input logic ie_r,
                     input logic [1:0] w, input logic [15:0] lim);
    bus_wr(2'd0, ctl(1'b0, daisy, ie_e, ie_r, w, lim));
    bus_wr(2'd0, ctl(1'b1, daisy, ie_e, ie_r, w, lim));
  endtask

  task automatic wait_ack();
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      bus_rd(2'd2, v);
      if (v[0]) return;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, nb, errs;
    logic [31:0] word;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(2'd0, v); chk("R1 ctrl", v, 32'h1);
    bus_rd(2'd1, v); chk("R1 status", v, 32'h0);
    bus_rd(2'd2, v); chk("R1 wack", v, 32'h0);
    chk("R1 irq/valid", {irq, cfg_valid, chain_valid}, 3'b000);

    // R2 writing 1 over 1 does not arm; unarmed data write
    bus_wr(2'd0, ctl(1, 0, 0, 0, 2'b10, 0));
    bus_rd(2'd1, v); chk("R2 no arm", v[3], 1'b0);
    bus_wr(2'd3, 32'h000000A5);
    bus_rd(2'd1, v); chk("R2 unarmed err", v[1:0], 2'b01);
    chk("R2 no bytes", loc_n, 0);

    // R10 arming clears error, sets armed and ready
    arm(0, 0, 0, 2'b10, 0);
    bus_rd(2'd1, v); chk("R10 status after arm", v, 32'h0000000C);
    bus_rd(2'd2, v); chk("R3 wack armed idle", v, 32'h1);

    // R5 bad preamble
    base = loc_n;
    bus_wr(2'd3, 32'h44332211);
    bus_rd(2'd1, v); chk("R5 sync err", v[1:0], 2'b11);
    chk("R5 dropped", loc_n - base, 0);
    bus_wr(2'd3, 32'h443322A5);
    wait_ack();
    chk("R5 sync then accepted", loc_n - base, 4);

    // R4 sweep of width codes
    for (int w = 0; w < 4; w++) begin
      arm(0, 0, 0, w[1:0], 0);
      nb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
      base = loc_n; errs = 0;
      for (int k = 0; k < 3; k++) begin
        word = 0;
        for (int j = 0; j < 4; j++) word[8*j +: 8] = 8'((w * 16 + k * 4 + j + 1) * 7);
        if (k == 0) word[7:0] = 8'hA5;
        bus_wr(2'd3, word);
        wait_ack();
        for (int j = 0; j < nb; j++)
          if (loc_b[base + k * nb + j] !== word[8*j +: 8]) errs++;
      end
      chk($sformatf("R4 count w=%0d", w), loc_n - base, 3 * nb);
      chk($sformatf("R4 bytes w=%0d", w), errs, 0);
    end

    // R11 and R6 under back-pressure
    arm(0, 0, 0, 2'b10, 0);
    base = loc_n;
    cfg_ready = 1'b0;
    bus_wr(2'd3, 32'h8877_66A5);
    held = cfg_byte;
    repeat (3) @(negedge clk);
    chk("R11 held byte", {cfg_valid, cfg_byte}, {1'b1, held});
    chk("R11 held value", held, 8'hA5);
    bus_rd(2'd2, v); chk("R3 wack busy", v, 32'h0);
    bus_wr(2'd3, 32'h1234_5678);
    bus_rd(2'd1, v); chk("R6 busy err", v[1:0], 2'b10);
    cfg_ready = 1'b1;
    wait_ack();
    repeat (3) @(negedge clk);
    chk("R6 only first word", loc_n - base, 4);
    chk("R6 first word bytes", {loc_b[base+3], loc_b[base+2], loc_b[base+1], loc_b[base]},
        32'h887766A5);

    // R7 daisy routing with limit 3
    arm(1, 0, 0, 2'b10, 16'd3);
    base = loc_n; nb = chn_n;
    bus_wr(2'd3, 32'h443322A5); wait_ack();
    bus_wr(2'd3, 32'h88776655); wait_ack();
    chk("R7 local count", loc_n - base, 3);
    chk("R7 chain count", chn_n - nb, 5);
    chk("R7 local bytes", {8'h0, loc_b[base+2], loc_b[base+1], loc_b[base]}, 32'h003322A5);
    chk("R7 chain bytes", {chn_b[nb+4], chn_b[nb+3], chn_b[nb+2], chn_b[nb+1]}, 32'h88776655);
    chk("R7 chain first", chn_b[nb], 8'h44);

    // R8 error interrupt, cleared by status read and by re-arm
    arm(0, 1, 0, 2'b00, 0);
    chk("R8 idle", irq, 1'b0);
    bus_wr(2'd3, 32'h00000011);
    chk("R8 raised", irq, 1'b1);
    bus_rd(2'd1, v);
    @(negedge clk);
    chk("R8 cleared by read", irq, 1'b0);
    bus_wr(2'd3, 32'h00000022);
    chk("R8 raised again", irq, 1'b1);
    arm(0, 1, 0, 2'b00, 0);
    chk("R8 cleared by arm", irq, 1'b0);

    // R9 ready interrupt
    arm(0, 0, 1, 2'b01, 0);
    bus_wr(2'd3, 32'h0000BBA5);
    repeat (4) @(negedge clk);
    chk("R9 raised", irq, 1'b1);
    bus_rd(2'd1, v);
    @(negedge clk);
    chk("R9 cleared by read", irq, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule